// File: doc/BRIEF.md
# Register Interlock Scoreboard with Forwarding

This block decides, every cycle, whether the instruction at the decode stage of a short in-order pipeline may proceed. The pipeline stages are fetch, decode, execute and store. The block keeps one ready bit for each architectural register. A ready bit drops when an instruction that writes that register leaves decode, and it rises again when the store stage writes the result back. Decode checks both source specifiers and the destination specifier of the waiting instruction against these bits. It holds the instruction while any of those three registers still has a write outstanding. While decode is held, fetch is frozen and execute receives a bubble.

A mode input selects between two policies. In pure interlock mode, every read-after-write dependency waits for writeback. In forwarding mode, a source that matches the destination of the instruction now in execute is taken from the ALU output over a bypass, so a back-to-back dependent pair issues without a gap. The block drives the operand-bus select lines for that bypass. Issue and stall counters let a bench measure the cost of a dependency. The block holds no register contents and does no fetch or branch handling.

Top module: `interlock_scoreboard`

## Requirements
- R1: After reset every register ready bit reads 1, the execute and store stages are empty, and both counters read 0.
- R2: An instruction that issues in cycle t leaves the ready bit of its destination at 0 from cycle t+1 until its writeback completes.
- R3: With forwarding off, a valid instruction whose source A or source B names a register with an outstanding write stalls (decStall=1, decIssue=0).
- R4: In both modes, a valid instruction whose destination names a register with an outstanding write stalls.
- R5: An instruction issued in cycle t occupies execute in cycle t+1 (exValid=1, exDst=its destination) and the store stage in cycle t+2 (wbValid=1, wbDst=its destination). Its ready bit reads 1 again from cycle t+3, unless another instruction writing the same register issued in cycle t+2.
- R6: A register written back in the current cycle counts as ready for the decode check in that same cycle.
- R7: With forwarding on, a source equal to exDst while exValid=1 does not stall, and the matching fwdSelA or fwdSelB line is 1 in the issuing cycle.
- R8: decIssue equals decValid and not decStall. A stalled cycle puts a bubble into execute in the next cycle (exValid=0). With decValid=0 the block neither stalls nor issues.
- R9: issueCount rises by one in each cycle that decIssue is 1, and stallCount rises by one in each cycle that decStall is 1. A back-to-back dependent pair costs one stall cycle with forwarding off and none with forwarding on.
- R10: Register 0 is an ordinary register and is tracked like any other.
- R11: fwdSelA and fwdSelB stay 0 whenever forwarding is off or nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fwdEn | input | 1 | 1 selects forwarding mode, 0 selects pure interlock |
| decValid | input | 1 | An instruction is present at decode |
| decSrcA | input | REG_W | First source register specifier |
| decSrcB | input | REG_W | Second source register specifier |
| decDst | input | REG_W | Destination register specifier |
| decStall | output | 1 | Hold decode and fetch this cycle |
| decIssue | output | 1 | Decode instruction moves to execute at the next edge |
| fwdSelA | output | 1 | Operand bus A takes the ALU result |
| fwdSelB | output | 1 | Operand bus B takes the ALU result |
| exValid | output | 1 | Execute stage holds an instruction |
| exDst | output | REG_W | Destination of the execute-stage instruction |
| wbValid | output | 1 | Store stage writes back this cycle |
| wbDst | output | REG_W | Register written back this cycle |
| regValid | output | 2**REG_W | Ready bit per register, 1 = no outstanding write |
| issueCount | output | CNT_W | Instructions issued since reset |
| stallCount | output | CNT_W | Stall cycles since reset |

## Verification
If a ready bit is wrong, the fault shows in the same cycle as a stall on decStall that should not happen, or as a missing stall. The error is also visible one cycle after the faulty update on the regValid port. Pipeline stage faults appear on exDst or wbDst one or two cycles after issue. Counter faults appear one cycle after the issue or stall that was miscounted. A behavioural reference model of the ready bits and the two stages is compared on every cycle, so any divergence is caught within one clock of the edge that caused it. The comparison runs through directed dependency pairs in both modes and through a random stream that is limited to a few registers to make hazards dense.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Decisions made by the control half for one decode cycle
  typedef struct packed {
    logic issue;
    logic stall;
    logic fwdA;
    logic fwdB;
  } sbStrobes_t;

  localparam int SB_NUM_SRC = 2;

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic                   fwdEn,
  input  logic                   decValid,
  input  logic [REG_W-1:0]       decSrcA,
  input  logic [REG_W-1:0]       decSrcB,
  input  logic [REG_W-1:0]       decDst,
  input  logic [(1<<REG_W)-1:0]  busyMask,
  input  logic                   exValid,
  input  logic [REG_W-1:0]       exDst,
  output sbStrobes_t             strobe
);

  logic [REG_W-1:0]      srcSpec [SB_NUM_SRC];
  logic [SB_NUM_SRC-1:0] srcFwd;
  logic [SB_NUM_SRC-1:0] srcHold;
  logic                  dstHold;
  logic                  stallNow;
  logic                  issueNow;

  assign srcSpec[0] = decSrcA;
  assign srcSpec[1] = decSrcB;

  // One hazard comparator per source operand
  generate
    for (genvar s = 0; s < SB_NUM_SRC; s++) begin : g_src
      assign srcFwd[s]  = fwdEn && exValid && (exDst == srcSpec[s]);
      assign srcHold[s] = busyMask[srcSpec[s]] && !srcFwd[s];
    end
  endgenerate

  // The destination never bypasses: a second write must wait for the first
  assign dstHold  = busyMask[decDst];
  assign stallNow = decValid && ((|srcHold) || dstHold);
  assign issueNow = decValid && !stallNow;

  always_comb begin
    strobe       = '0;
    strobe.stall = stallNow;
    strobe.issue = issueNow;
    strobe.fwdA  = issueNow && srcFwd[0];
    strobe.fwdB  = issueNow && srcFwd[1];
  end

endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sbStrobes_t             strobe,
  input  logic [REG_W-1:0]       decDst,
  output logic                   decIssue,
  output logic                   decStall,
  output logic                   fwdSelA,
  output logic                   fwdSelB,
  output logic [(1<<REG_W)-1:0]  busyMask,
  output logic [(1<<REG_W)-1:0]  regValid,
  output logic                   exValid,
  output logic [REG_W-1:0]       exDst,
  output logic                   wbValid,
  output logic [REG_W-1:0]       wbDst,
  output logic [CNT_W-1:0]       issueCount,
  output logic [CNT_W-1:0]       stallCount
);

  localparam int NUM_REGS = 1 << REG_W;

  logic [NUM_REGS-1:0] readyQ;

  // One ready flop per architectural register
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic markHit;
      logic wbHit;
      assign markHit = strobe.issue && (decDst == REG_W'(g));
      assign wbHit   = wbValid && (wbDst == REG_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        readyQ[g] <= 1'b1;
        else if (markHit) readyQ[g] <= 1'b0;
        else if (wbHit)   readyQ[g] <= 1'b1;
      end

      // Same-cycle writeback makes the register visible as ready
      assign busyMask[g] = !readyQ[g] && !wbHit;
    end
  endgenerate

  // Execute and store stage tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exValid <= 1'b0;
      exDst   <= '0;
      wbValid <= 1'b0;
      wbDst   <= '0;
    end else begin
      exValid <= strobe.issue;
      if (strobe.issue) exDst <= decDst;
      wbValid <= exValid;
      if (exValid) wbDst <= exDst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueCount <= '0;
      stallCount <= '0;
    end else begin
      if (strobe.issue) issueCount <= issueCount + CNT_W'(1);
      if (strobe.stall) stallCount <= stallCount + CNT_W'(1);
    end
  end

  assign regValid = readyQ;
  assign decIssue = strobe.issue;
  assign decStall = strobe.stall;
  assign fwdSelA  = strobe.fwdA;
  assign fwdSelB  = strobe.fwdB;

endmodule

// File: rtl/interlock_scoreboard.sv
module interlock_scoreboard
  import sb_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fwdEn,
  input  logic                   decValid,
  input  logic [REG_W-1:0]       decSrcA,
  input  logic [REG_W-1:0]       decSrcB,
  input  logic [REG_W-1:0]       decDst,
  output logic                   decStall,
  output logic                   decIssue,
  output logic                   fwdSelA,
  output logic                   fwdSelB,
  output logic                   exValid,
  output logic [REG_W-1:0]       exDst,
  output logic                   wbValid,
  output logic [REG_W-1:0]       wbDst,
  output logic [(1<<REG_W)-1:0]  regValid,
  output logic [CNT_W-1:0]       issueCount,
  output logic [CNT_W-1:0]       stallCount
);

  sbStrobes_t           strobe;
  logic [(1<<REG_W)-1:0] busyMask;

  sb_ctrl #(.REG_W(REG_W)) u_ctrl (
    .fwdEn    (fwdEn),
    .decValid (decValid),
    .decSrcA  (decSrcA),
    .decSrcB  (decSrcB),
    .decDst   (decDst),
    .busyMask (busyMask),
    .exValid  (exValid),
    .exDst    (exDst),
    .strobe   (strobe)
  );

  sb_datapath #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .decDst     (decDst),
    .decIssue   (decIssue),
    .decStall   (decStall),
    .fwdSelA    (fwdSelA),
    .fwdSelB    (fwdSelB),
    .busyMask   (busyMask),
    .regValid   (regValid),
    .exValid    (exValid),
    .exDst      (exDst),
    .wbValid    (wbValid),
    .wbDst      (wbDst),
    .issueCount (issueCount),
    .stallCount (stallCount)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int REG_W = 4,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   fwdEn,
  input logic                   decValid,
  input logic [REG_W-1:0]       decSrcA,
  input logic [REG_W-1:0]       decSrcB,
  input logic [REG_W-1:0]       decDst,
  input logic                   decStall,
  input logic                   decIssue,
  input logic                   fwdSelA,
  input logic                   fwdSelB,
  input logic                   exValid,
  input logic [REG_W-1:0]       exDst,
  input logic                   wbValid,
  input logic [REG_W-1:0]       wbDst,
  input logic [(1<<REG_W)-1:0]  regValid,
  input logic [CNT_W-1:0]       issueCount,
  input logic [CNT_W-1:0]       stallCount
);

  AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    decIssue |=> !regValid[$past(decDst)]); // R2

  AST_EX_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    decIssue |=> (exValid && exDst == $past(decDst))); // R5

  AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    exValid |=> (wbValid && wbDst == $past(exDst))); // R5

  AST_DST_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !regValid[decDst] && !(wbValid && wbDst == decDst)) |-> decStall); // R4

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    decStall |=> !exValid); // R8

  AST_ISSUE_XOR_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !(decIssue && decStall)); // R8

  AST_FWD_MATCH_A: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelA |-> (fwdEn && exValid && exDst == decSrcA)); // R7

  AST_FWD_MATCH_B: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelB |-> (fwdEn && exValid && exDst == decSrcB)); // R7

  AST_NO_FWD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!fwdEn || !decIssue) |-> (!fwdSelA && !fwdSelB)); // R11

  AST_STALL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    decStall |=> (stallCount == $past(stallCount) + CNT_W'(1))); // R9

  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    decIssue |=> (issueCount == $past(issueCount) + CNT_W'(1))); // R9

endmodule

bind interlock_scoreboard sb_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fwdEn      (fwdEn),
  .decValid   (decValid),
  .decSrcA    (decSrcA),
  .decSrcB    (decSrcB),
  .decDst     (decDst),
  .decStall   (decStall),
  .decIssue   (decIssue),
  .fwdSelA    (fwdSelA),
  .fwdSelB    (fwdSelB),
  .exValid    (exValid),
  .exDst      (exDst),
  .wbValid    (wbValid),
  .wbDst      (wbDst),
  .regValid   (regValid),
  .issueCount (issueCount),
  .stallCount (stallCount)
);

// File: tb/sim_interlock_scoreboard.sv
module sim_interlock_scoreboard;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 4;
  localparam int CNT_W      = 16;
  localparam int NREG       = 1 << REG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fwdEn = 1'b0;
  logic decValid = 1'b0;
  logic [REG_W-1:0] decSrcA = '0, decSrcB = '0, decDst = '0;
  logic decStall, decIssue, fwdSelA, fwdSelB, exValid, wbValid;
  logic [REG_W-1:0] exDst, wbDst;
  logic [NREG-1:0] regValid;
  logic [CNT_W-1:0] issueCount, stallCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  bit mReady [NREG];
  bit mExV, mWbV;
  int mExD, mWbD;
  int mIss, mStl;
  bit eIssue;

  always #(CLK_PERIOD/2) clk = ~clk;

  interlock_scoreboard #(.REG_W(REG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .fwdEn(fwdEn), .decValid(decValid),
    .decSrcA(decSrcA), .decSrcB(decSrcB), .decDst(decDst),
    .decStall(decStall), .decIssue(decIssue), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .exValid(exValid), .exDst(exDst), .wbValid(wbValid), .wbDst(wbDst),
    .regValid(regValid), .issueCount(issueCount), .stallCount(stallCount)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit busy(int r);
    return !mReady[r] && !(mWbV && mWbD == r);
  endfunction

  task automatic modelReset();
    for (int r = 0; r < NREG; r++) mReady[r] = 1'b1;
    mExV = 0; mWbV = 0; mExD = 0; mWbD = 0; mIss = 0; mStl = 0;
  endtask

  // Drive one decode slot and compare every output against the model
  task automatic apply(bit fe, bit dv, int a, int b, int d);
    bit fa, fb, st;
    logic [NREG-1:0] ev;
    @(negedge clk);
    fwdEn = fe; decValid = dv;
    decSrcA = REG_W'(a); decSrcB = REG_W'(b); decDst = REG_W'(d);
    #1;
    fa = fe && mExV && mExD == a;
    fb = fe && mExV && mExD == b;
    st = dv && ((busy(a) && !fa) || (busy(b) && !fb) || busy(d));
    eIssue = dv && !st;
    for (int r = 0; r < NREG; r++) ev[r] = mReady[r];
    check("R3/R4 decStall", 32'(decStall), 32'(st));
    check("R8 decIssue", 32'(decIssue), 32'(eIssue));
    check("R7/R11 fwdSelA", 32'(fwdSelA), 32'(eIssue && fa));
    check("R7/R11 fwdSelB", 32'(fwdSelB), 32'(eIssue && fb));
    check("R5 exValid", 32'(exValid), 32'(mExV));
    if (mExV) check("R5 exDst", 32'(exDst), 32'(mExD));
    check("R5 wbValid", 32'(wbValid), 32'(mWbV));
    if (mWbV) check("R5 wbDst", 32'(wbDst), 32'(mWbD));
    check("R2 regValid", 32'(regValid), 32'(ev));
    check("R9 issueCount", 32'(issueCount), 32'(CNT_W'(mIss)));
    check("R9 stallCount", 32'(stallCount), 32'(CNT_W'(mStl)));
  endtask

  task automatic advance();
    @(posedge clk);
    if (mWbV) mReady[mWbD] = 1'b1;
    if (eIssue) mReady[decDst] = 1'b0;
    mWbV = mExV; mWbD = mExD;
    mExV = eIssue; mExD = int'(decDst);
    if (eIssue) mIss++;
    if (decValid && !eIssue) mStl++;
  endtask

  task automatic step(bit fe, bit dv, int a, int b, int d);
    apply(fe, dv, a, b, d);
    advance();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int s0;
    modelReset();
    eIssue = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1 regValid", 32'(regValid), 32'hFFFF);
    check("R1 exValid", 32'(exValid), 0);
    check("R1 wbValid", 32'(wbValid), 0);
    check("R1 counts", 32'(issueCount) + 32'(stallCount), 0);

    // Interlock mode: r1 <- r2,r3 then r4 <- r1,r5
    s0 = mStl;
    step(0, 1, 2, 3, 1);
    apply(0, 1, 1, 5, 4);
    check("R3 interlock source stall", 32'(decStall), 1);
    advance();
    apply(0, 1, 1, 5, 4);
    check("R6 same-cycle writeback issues", 32'(decIssue), 1);
    check("R11 no forward in interlock mode", 32'(fwdSelA), 0);
    advance();
    check("R9 interlock pair costs one stall", 32'(mStl - s0), 1);
    step(0, 0, 0, 0, 0);
    apply(0, 0, 4, 4, 4);
    check("R8 idle does not stall", 32'(decStall), 0);
    advance();
    repeat (3) step(0, 0, 0, 0, 0);

    // Forwarding mode: r6 <- r2,r3 then r7 <- r6,r6
    s0 = mStl;
    step(1, 1, 2, 3, 6);
    apply(1, 1, 6, 6, 7);
    check("R7 forwarded pair issues", 32'(decIssue), 1);
    check("R7 both buses forwarded", 32'({fwdSelA, fwdSelB}), 3);
    advance();
    check("R9 forwarded pair costs no stall", 32'(mStl - s0), 0);
    repeat (3) step(1, 0, 0, 0, 0);

    // Destination hazard holds even with forwarding
    step(1, 1, 1, 1, 8);
    apply(1, 1, 2, 2, 8);
    check("R4 destination hazard stalls", 32'(decStall), 1);
    advance();
    step(1, 1, 2, 2, 8);
    repeat (3) step(1, 0, 0, 0, 0);

    // Register 0 tracked as ordinary, hazard on source B
    step(0, 1, 3, 3, 0);
    apply(0, 1, 5, 0, 9);
    check("R10 register 0 hazard on source B", 32'(decStall), 1);
    advance();
    apply(0, 0, 0, 0, 0);
    check("R8 bubble after stall", 32'(exValid), 0);
    advance();
    repeat (3) step(0, 0, 0, 0, 0);

    // Dense random stream over a few registers, both modes
    for (int i = 0; i < 600; i++) begin
      bit fe;
      fe = (i / 150) % 2 == 1;
      step(fe, ($urandom % 4) != 0, $urandom % 4, $urandom % 4, $urandom % 4);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule